// File: doc/BRIEF.md
# Syntactic Store-to-Load Forwarding Predictor

This block sits beside the decode and rename stage and guesses, before any address is formed, that a load will read the location that a recent store wrote. It decides only from how the two memory operands are written: the same base register, the same index register and scale, and the same short displacement. A small fully associative table holds recent qualifying stores. Each entry keeps the rename tag of the register that supplied the store's data. When a later load presents the same operand form, the block returns that tag so that rename can connect the load's destination to the store's source and skip the memory round trip.

The guess is speculative. Two differently written operands may alias, and two identically written ones may not. Confirming the guess and recovering from a wrong one belong to later stages. Their only effect on this block is the `flush` input, which empties the table. Register writes reported on the write port drop every entry that uses the written register in its address, so that a later match cannot rest on a changed pointer. Push and pop move the stack pointer themselves, and the block rebases the stack-relative entries to follow.

Top module: `syntaxForwardPredictor`

## Requirements
- R1: A request with `reqDataGpr`=0 (data register not general purpose) never creates an entry and never produces a hit.
- R2: `reqSize` encodes 0=8, 1=16, 2=32, 3=64 bits. Only sizes 2 and 3 are eligible. A request of size 0 or 1 neither inserts nor hits.
- R3: A 32-bit load hits an entry made by a 32-bit or a 64-bit store. A 64-bit load hits only an entry made by a 64-bit store.
- R4: For kinds other than push and pop, a request is eligible only with `reqHasBase`=1 and `reqIpRel`=0, and with a `reqDisp` that lies in -128..127 as a signed value.
- R5: A hit needs equal base register, equal index presence and, when an index is present, equal index register and scale, plus an equal displacement. With no index, `reqIndex` and `reqScale` are ignored.
- R6: A request with `reqLineCross`=1 neither inserts nor hits.
- R7: `reqKind` encodes 0=load move, 1=store move, 2=read-modify, 3=read-modify-write, 4=push, 5=pop, 6=multi-µop, 7=other. Kinds 0, 2, 3 and 5 look up. Kinds 1, 3 and 4 insert with `reqDataTag`. Kind 3 looks up before it inserts. Kinds 6 and 7 do neither.
- R8: `wrValid` with `wrReg` removes every entry whose base register, or whose present index register, equals `wrReg`. This includes a lookup in the same cycle, which then misses. A store issued in the same cycle as such a write is kept.
- R9: Push and pop address the stack pointer (register `SP_REG`, default 4) at displacement 0 with no index. An eligible push adds 4 or 8 (its size) to the displacement of every stack-relative entry before it inserts. An eligible pop looks up first and then subtracts its size. An entry that leaves -128..127 is dropped. An ineligible push or pop drops every entry that uses the stack pointer.
- R10: The table holds `ENTRIES` (default 8) entries. A store whose key matches a live entry overwrites that entry in place. Any other store takes the slot named by a round-robin pointer, which then advances, so the oldest allocation is replaced.
- R11: `flush` empties the table in one cycle. A lookup in the flush cycle misses, and a store in that cycle is not kept.
- R12: `hitValid` and `hitTag` are registered and reflect the request of the previous cycle. With no hit, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Misprediction recovery; empties the table |
| reqValid | input | 1 | Memory µop present this cycle |
| reqKind | input | 3 | µop kind, encoded as in R7 |
| reqSize | input | 2 | Operand size code, encoded as in R2 |
| reqDataGpr | input | 1 | Data operand is a general-purpose register |
| reqHasBase | input | 1 | Operand has a base register |
| reqIpRel | input | 1 | Operand is instruction-pointer relative |
| reqBase | input | 4 | Base register number |
| reqHasIndex | input | 1 | Operand has an index register |
| reqIndex | input | 4 | Index register number |
| reqScale | input | 2 | Index scale code |
| reqDisp | input | DISP_W | Displacement as written, signed |
| reqLineCross | input | 1 | Precomputed cache-line crossing flag |
| reqDataTag | input | TAG_W | Rename tag of a store's data source |
| wrValid | input | 1 | An architectural register is written this cycle |
| wrReg | input | 4 | Number of the register written |
| hitValid | output | 1 | Previous lookup found a matching entry |
| hitTag | output | TAG_W | Data tag of the matching entry, 0 on miss |

## Verification
A register write can arrive in the same cycle as a lookup or a store that names the written register. The bench issues a load with `wrValid` raised on its base register and expects a miss one cycle later. It also issues a store together with such a write and expects a following load to hit. In the same way, a flush raised with a load must give a miss, and a read-modify-write must both return the older store's tag and leave its own tag for the next read.

// File: rtl/sfpPkg.sv
package sfpPkg;

  localparam int REG_W   = 4;
  localparam int DSP_W   = 8;
  localparam int SHIFT_W = 4;

  typedef enum logic [2:0] {
    KIND_LDMOV = 3'd0,
    KIND_STMOV = 3'd1,
    KIND_RDMOD = 3'd2,
    KIND_RMW   = 3'd3,
    KIND_PUSH  = 3'd4,
    KIND_POP   = 3'd5,
    KIND_MULTI = 3'd6,
    KIND_OTHER = 3'd7
  } uopKind_e;

  typedef struct packed {
    logic [REG_W-1:0] base;
    logic             hasIdx;
    logic [REG_W-1:0] idx;
    logic [1:0]       scale;
    logic [DSP_W-1:0] disp;
  } addrKey_t;

  typedef struct packed {
    logic               clearAll;
    logic               lookup;
    logic               lookupWide;
    logic               insert;
    logic               insertWide;
    logic               stackShift;
    logic               stackUp;
    logic [SHIFT_W-1:0] shiftAmt;
    logic               stackKill;
    logic               regKill;
    logic [REG_W-1:0]   regKillId;
    addrKey_t           key;
  } ctrlStrobe_t;

endpackage

// File: rtl/sfpControl.sv
module sfpControl
  import sfpPkg::*;
#(
  parameter int DISP_W = 32,
  parameter int SP_REG = 4
) (
  input  logic              flush,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [1:0]        reqSize,
  input  logic              reqDataGpr,
  input  logic              reqHasBase,
  input  logic              reqIpRel,
  input  logic [REG_W-1:0]  reqBase,
  input  logic              reqHasIndex,
  input  logic [REG_W-1:0]  reqIndex,
  input  logic [1:0]        reqScale,
  input  logic [DISP_W-1:0] reqDisp,
  input  logic              reqLineCross,
  input  logic              wrValid,
  input  logic [REG_W-1:0]  wrReg,
  output ctrlStrobe_t       strobe
);

  localparam logic [REG_W-1:0] SP_ID = REG_W'(SP_REG);
  localparam int HI_W = DISP_W - DSP_W + 1;

  uopKind_e kind;
  logic isStack, loadSide, storeSide;
  logic dataOk, dispFits, addrOk, eligible;
  logic [HI_W-1:0] dispHigh;

  always_comb begin
    kind      = uopKind_e'(reqKind);
    isStack   = (kind == KIND_PUSH) || (kind == KIND_POP);
    loadSide  = (kind == KIND_LDMOV) || (kind == KIND_RDMOD) ||
                (kind == KIND_RMW)   || (kind == KIND_POP);
    storeSide = (kind == KIND_STMOV) || (kind == KIND_RMW) ||
                (kind == KIND_PUSH);

    // the displacement fits 8 signed bits when its sign extension is uniform
    dispHigh = reqDisp[DISP_W-1:DSP_W-1];
    dispFits = (&dispHigh) || !(|dispHigh);

    dataOk   = reqDataGpr && reqSize[1] && !reqLineCross;
    addrOk   = isStack || (reqHasBase && !reqIpRel && dispFits);
    eligible = reqValid && dataOk && addrOk && (loadSide || storeSide);

    strobe            = '0;
    strobe.clearAll   = flush;
    strobe.lookup     = !flush && eligible && loadSide;
    strobe.lookupWide = reqSize[0];
    strobe.insert     = !flush && eligible && storeSide;
    strobe.insertWide = reqSize[0];
    strobe.stackShift = !flush && eligible && isStack;
    strobe.stackKill  = !flush && reqValid && isStack && !eligible;
    strobe.stackUp    = (kind == KIND_PUSH);
    strobe.shiftAmt   = reqSize[0] ? SHIFT_W'(8) : SHIFT_W'(4);
    strobe.regKill    = !flush && wrValid;
    strobe.regKillId  = wrReg;

    if (isStack) begin
      strobe.key.base   = SP_ID;
      strobe.key.hasIdx = 1'b0;
      strobe.key.idx    = '0;
      strobe.key.scale  = '0;
      strobe.key.disp   = '0;
    end else begin
      strobe.key.base   = reqBase;
      strobe.key.hasIdx = reqHasIndex;
      strobe.key.idx    = reqHasIndex ? reqIndex : '0;
      strobe.key.scale  = reqHasIndex ? reqScale : '0;
      strobe.key.disp   = reqDisp[DSP_W-1:0];
    end
  end

endmodule

// File: rtl/sfpDatapath.sv
module sfpDatapath
  import sfpPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int SP_REG  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [TAG_W-1:0] dataTag,
  output logic             hitValid,
  output logic [TAG_W-1:0] hitTag
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [REG_W-1:0] SP_ID = REG_W'(SP_REG);
  localparam int PAD_W = DSP_W + 1 - SHIFT_W;

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entWide;
  addrKey_t           entKey [ENTRIES];
  logic [TAG_W-1:0]   entTag [ENTRIES];
  logic [PTR_W-1:0]   wrPtr;

  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] liveNext;
  logic [ENTRIES-1:0] sameKey;
  addrKey_t           keyNext [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic     usesReg, usesSp, onSp, liveA, liveB, hitL;
    logic [DSP_W:0] moved;
    addrKey_t keyB;

    always_comb begin
      usesReg = (entKey[g].base == strobe.regKillId) ||
                (entKey[g].hasIdx && (entKey[g].idx == strobe.regKillId));
      liveA   = entValid[g] && !(strobe.regKill && usesReg);
      hitL    = liveA && strobe.lookup && (entKey[g] == strobe.key) &&
                (entWide[g] || !strobe.lookupWide);

      usesSp  = (entKey[g].base == SP_ID) ||
                (entKey[g].hasIdx && (entKey[g].idx == SP_ID));
      onSp    = (entKey[g].base == SP_ID) && !entKey[g].hasIdx;
      if (strobe.stackUp)
        moved = {entKey[g].disp[DSP_W-1], entKey[g].disp} + {{PAD_W{1'b0}}, strobe.shiftAmt};
      else
        moved = {entKey[g].disp[DSP_W-1], entKey[g].disp} - {{PAD_W{1'b0}}, strobe.shiftAmt};

      keyB  = entKey[g];
      liveB = liveA;
      if (strobe.stackKill && usesSp) liveB = 1'b0;
      if (strobe.stackShift && usesSp) begin
        if (onSp && (moved[DSP_W] == moved[DSP_W-1])) keyB.disp = moved[DSP_W-1:0];
        else liveB = 1'b0;
      end
    end

    assign hitVec[g]   = hitL;
    assign liveNext[g] = liveB;
    assign keyNext[g]  = keyB;
    assign sameKey[g]  = liveB && (keyB == strobe.key);
  end

  logic [PTR_W-1:0] slot;
  logic             reuse;
  logic [TAG_W-1:0] hitMux;

  always_comb begin
    slot  = wrPtr;
    reuse = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!reuse && sameKey[i]) begin
        slot  = PTR_W'(i);
        reuse = 1'b1;
      end
    end
    hitMux = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) hitMux = hitMux | entTag[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      entValid <= '0;
      entWide  <= '0;
      wrPtr    <= '0;
      hitValid <= 1'b0;
      hitTag   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entKey[i] <= '0;
        entTag[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        entValid[i] <= liveNext[i];
        entKey[i]   <= keyNext[i];
      end
      if (strobe.insert) begin
        entValid[slot] <= 1'b1;
        entKey[slot]   <= strobe.key;
        entWide[slot]  <= strobe.insertWide;
        entTag[slot]   <= dataTag;
        if (!reuse) wrPtr <= (wrPtr == PTR_W'(ENTRIES - 1)) ? '0 : wrPtr + 1'b1;
      end
      hitValid <= |hitVec;
      hitTag   <= hitMux;
    end
  end

endmodule

// File: rtl/syntaxForwardPredictor.sv
module syntaxForwardPredictor
  import sfpPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int DISP_W  = 32,
  parameter int SP_REG  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [1:0]        reqSize,
  input  logic              reqDataGpr,
  input  logic              reqHasBase,
  input  logic              reqIpRel,
  input  logic [REG_W-1:0]  reqBase,
  input  logic              reqHasIndex,
  input  logic [REG_W-1:0]  reqIndex,
  input  logic [1:0]        reqScale,
  input  logic [DISP_W-1:0] reqDisp,
  input  logic              reqLineCross,
  input  logic [TAG_W-1:0]  reqDataTag,
  input  logic              wrValid,
  input  logic [REG_W-1:0]  wrReg,
  output logic              hitValid,
  output logic [TAG_W-1:0]  hitTag
);

  ctrlStrobe_t strobe;

  sfpControl #(.DISP_W(DISP_W), .SP_REG(SP_REG)) u_control (
    .flush(flush), .reqValid(reqValid), .reqKind(reqKind), .reqSize(reqSize),
    .reqDataGpr(reqDataGpr), .reqHasBase(reqHasBase), .reqIpRel(reqIpRel),
    .reqBase(reqBase), .reqHasIndex(reqHasIndex), .reqIndex(reqIndex),
    .reqScale(reqScale), .reqDisp(reqDisp), .reqLineCross(reqLineCross),
    .wrValid(wrValid), .wrReg(wrReg), .strobe(strobe)
  );

  sfpDatapath #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .SP_REG(SP_REG)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataTag(reqDataTag),
    .hitValid(hitValid), .hitTag(hitTag)
  );

endmodule

// File: rtl/sfpChecker.sv
module sfpChecker
  import sfpPkg::*;
#(
  parameter int TAG_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             reqValid,
  input logic [2:0]       reqKind,
  input logic [1:0]       reqSize,
  input logic             reqDataGpr,
  input logic             reqHasBase,
  input logic             reqIpRel,
  input logic [REG_W-1:0] reqBase,
  input logic             reqLineCross,
  input logic             wrValid,
  input logic [REG_W-1:0] wrReg,
  input logic             hitValid,
  input logic [TAG_W-1:0] hitTag
);

  logic plainLoad;
  assign plainLoad = (reqKind == 3'd0) || (reqKind == 3'd2) || (reqKind == 3'd3);

  // R12
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !hitValid);

  // R12
  miss_tag_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (hitTag == '0));

  // R11
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !hitValid);

  // R1
  non_gpr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqDataGpr) |=> !hitValid);

  // R2
  narrow_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqSize[1]) |=> !hitValid);

  // R6
  line_cross_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqLineCross) |=> !hitValid);

  // R7
  no_lookup_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ((reqKind == 3'd1) || (reqKind == 3'd4) || (reqKind >= 3'd6))) |=> !hitValid);

  // R4
  bad_address_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && plainLoad && (reqIpRel || !reqHasBase)) |=> !hitValid);

  // R8
  base_written_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && plainLoad && wrValid && (wrReg == reqBase)) |=> !hitValid);

endmodule

bind syntaxForwardPredictor sfpChecker #(.TAG_W(TAG_W)) u_sfpChecker (
  .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid), .reqKind(reqKind),
  .reqSize(reqSize), .reqDataGpr(reqDataGpr), .reqHasBase(reqHasBase),
  .reqIpRel(reqIpRel), .reqBase(reqBase), .reqLineCross(reqLineCross),
  .wrValid(wrValid), .wrReg(wrReg), .hitValid(hitValid), .hitTag(hitTag)
);

// File: tb/test_syntaxForwardPredictor.sv
`timescale 1ns/1ps
module test_syntaxForwardPredictor;

  localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_RDMOD = 3'd2, K_RMW = 3'd3,
                         K_PUSH = 3'd4, K_POP = 3'd5, K_MULTI = 3'd6, K_OTHER = 3'd7;
  localparam logic [3:0] SP = 4'd4;

  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0;
  logic reqValid = 1'b0, reqDataGpr = 1'b1, reqHasBase = 1'b1, reqIpRel = 1'b0;
  logic reqHasIndex = 1'b0, reqLineCross = 1'b0, wrValid = 1'b0;
  logic [2:0] reqKind = '0;
  logic [1:0] reqSize = '0, reqScale = '0;
  logic [3:0] reqBase = '0, reqIndex = '0, wrReg = '0;
  logic [31:0] reqDisp = '0;
  logic [5:0] reqDataTag = '0;
  logic hitValid;
  logic [5:0] hitTag;

  int checks = 0, fails = 0;
  logic modGpr = 1'b1, modBase = 1'b1, modIp = 1'b0, modCross = 1'b0;
  logic modWr = 1'b0, modFlush = 1'b0;
  logic [3:0] modWrReg = '0;

  always #10 clk = ~clk;

  syntaxForwardPredictor i_syntaxForwardPredictor (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid), .reqKind(reqKind),
    .reqSize(reqSize), .reqDataGpr(reqDataGpr), .reqHasBase(reqHasBase),
    .reqIpRel(reqIpRel), .reqBase(reqBase), .reqHasIndex(reqHasIndex),
    .reqIndex(reqIndex), .reqScale(reqScale), .reqDisp(reqDisp),
    .reqLineCross(reqLineCross), .reqDataTag(reqDataTag), .wrValid(wrValid),
    .wrReg(wrReg), .hitValid(hitValid), .hitTag(hitTag)
  );

  task automatic chk(input string rq, input logic expHit, input logic [5:0] expTag);
    checks++;
    if (hitValid !== expHit || hitTag !== expTag) begin
      fails++;
      $display("FAIL %s: hit=%0b tag=%0d, expected hit=%0b tag=%0d",
               rq, hitValid, hitTag, expHit, expTag);
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic [1:0] sz, input logic [3:0] b,
                       input logic hx, input logic [3:0] ix, input logic [1:0] sc,
                       input int d, input logic [5:0] tg);
    reqValid = 1'b1; reqKind = k; reqSize = sz; reqBase = b; reqHasIndex = hx;
    reqIndex = ix; reqScale = sc; reqDisp = 32'(d); reqDataTag = tg;
    reqDataGpr = modGpr; reqHasBase = modBase; reqIpRel = modIp; reqLineCross = modCross;
    wrValid = modWr; wrReg = modWrReg; flush = modFlush;
    @(negedge clk);
    reqValid = 1'b0; wrValid = 1'b0; flush = 1'b0;
    modGpr = 1'b1; modBase = 1'b1; modIp = 1'b0; modCross = 1'b0; modWr = 1'b0; modFlush = 1'b0;
  endtask

  task automatic st(input logic [1:0] sz, input logic [3:0] b, input int d, input logic [5:0] tg);
    issue(K_ST, sz, b, 1'b0, 4'd0, 2'd0, d, tg);
  endtask

  task automatic ld(input logic [1:0] sz, input logic [3:0] b, input int d);
    issue(K_LD, sz, b, 1'b0, 4'd0, 2'd0, d, 6'd0);
  endtask

  task automatic doFlush();
    flush = 1'b1; @(negedge clk); flush = 1'b0;
  endtask

  task automatic regWrite(input logic [3:0] r);
    wrValid = 1'b1; wrReg = r; @(negedge clk); wrValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired, all requirements unfinished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 reset state", 1'b0, 6'd0);

    // R2 / R3 size sweep: hit iff both eligible and not wide-load over narrow-store
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 4; l++) begin
        logic e;
        doFlush();
        st(2'(s), 4'd1, 16, 6'd5);
        ld(2'(l), 4'd1, 16);
        e = (s >= 2) && (l >= 2) && !(s == 2 && l == 3);
        chk((s < 2 || l < 2) ? "R2 size eligibility" : "R3 width rule", e, e ? 6'd5 : 6'd0);
      end
    end

    // R4 displacement range sweep
    for (int d = -136; d <= 136; d++) begin
      logic e;
      doFlush();
      st(2'd3, 4'd2, d, 6'd9);
      ld(2'd3, 4'd2, d);
      e = (d >= -128) && (d <= 127);
      chk("R4 displacement range", e, e ? 6'd9 : 6'd0);
    end

    // R5 key field sweep
    doFlush();
    issue(K_ST, 2'd3, 4'd2, 1'b1, 4'd3, 2'd1, 4, 6'd12);
    for (int f = 0; f < 6; f++) begin
      case (f)
        0: issue(K_LD, 2'd3, 4'd2, 1'b1, 4'd3, 2'd1, 4, 6'd0);
        1: issue(K_LD, 2'd3, 4'd5, 1'b1, 4'd3, 2'd1, 4, 6'd0);
        2: issue(K_LD, 2'd3, 4'd2, 1'b0, 4'd3, 2'd1, 4, 6'd0);
        3: issue(K_LD, 2'd3, 4'd2, 1'b1, 4'd5, 2'd1, 4, 6'd0);
        4: issue(K_LD, 2'd3, 4'd2, 1'b1, 4'd3, 2'd2, 4, 6'd0);
        default: issue(K_LD, 2'd3, 4'd2, 1'b1, 4'd3, 2'd1, 5, 6'd0);
      endcase
      chk("R5 key field match", f == 0, (f == 0) ? 6'd12 : 6'd0);
    end
    doFlush();
    issue(K_ST, 2'd3, 4'd2, 1'b0, 4'd7, 2'd3, 4, 6'd13);
    issue(K_LD, 2'd3, 4'd2, 1'b0, 4'd1, 2'd0, 4, 6'd0);
    chk("R5 index fields ignored without index", 1'b1, 6'd13);

    // R1 / R4 / R6 operand flags, on the store side and on the load side
    for (int f = 0; f < 4; f++) begin
      for (int side = 0; side < 2; side++) begin
        doFlush();
        if (side == 0) begin
          case (f) 0: modGpr = 1'b0; 1: modBase = 1'b0; 2: modIp = 1'b1; default: modCross = 1'b1; endcase
        end
        st(2'd3, 4'd1, 0, 6'd21);
        if (side == 1) begin
          case (f) 0: modGpr = 1'b0; 1: modBase = 1'b0; 2: modIp = 1'b1; default: modCross = 1'b1; endcase
        end
        ld(2'd3, 4'd1, 0);
        case (f)
          0: chk("R1 non-GPR ignored", 1'b0, 6'd0);
          1: chk("R4 missing base ignored", 1'b0, 6'd0);
          2: chk("R4 ip-relative ignored", 1'b0, 6'd0);
          default: chk("R6 line crossing ignored", 1'b0, 6'd0);
        endcase
      end
    end

    // R7 kinds
    doFlush();
    issue(K_RMW, 2'd3, 4'd1, 1'b0, 4'd0, 2'd0, 0, 6'd17);
    issue(K_RDMOD, 2'd3, 4'd1, 1'b0, 4'd0, 2'd0, 0, 6'd0);
    chk("R7 read-modify sees RMW store", 1'b1, 6'd17);
    issue(K_RMW, 2'd3, 4'd1, 1'b0, 4'd0, 2'd0, 0, 6'd18);
    chk("R7 RMW looks up before insert", 1'b1, 6'd17);
    issue(K_RDMOD, 2'd3, 4'd1, 1'b0, 4'd0, 2'd0, 0, 6'd0);
    chk("R7 RMW inserted its tag", 1'b1, 6'd18);
    doFlush();
    issue(K_MULTI, 2'd3, 4'd1, 1'b0, 4'd0, 2'd0, 0, 6'd19);
    ld(2'd3, 4'd1, 0);
    chk("R7 multi-uop not inserted", 1'b0, 6'd0);
    st(2'd3, 4'd1, 0, 6'd20);
    chk("R7 store move gives no hit", 1'b0, 6'd0);
    issue(K_MULTI, 2'd3, 4'd1, 1'b0, 4'd0, 2'd0, 0, 6'd0);
    chk("R7 multi-uop no lookup", 1'b0, 6'd0);
    issue(K_OTHER, 2'd3, 4'd1, 1'b0, 4'd0, 2'd0, 0, 6'd0);
    chk("R7 other kind no lookup", 1'b0, 6'd0);
    ld(2'd3, 4'd1, 0);
    chk("R7 load move hit", 1'b1, 6'd20);
    @(negedge clk);
    chk("R12 no hit on idle cycle", 1'b0, 6'd0);

    // R8 register write invalidation
    doFlush();
    issue(K_ST, 2'd3, 4'd2, 1'b1, 4'd3, 2'd0, 8, 6'd14);
    regWrite(4'd3);
    issue(K_LD, 2'd3, 4'd2, 1'b1, 4'd3, 2'd0, 8, 6'd0);
    chk("R8 index write drops entry", 1'b0, 6'd0);
    issue(K_ST, 2'd3, 4'd2, 1'b1, 4'd3, 2'd0, 8, 6'd15);
    regWrite(4'd6);
    issue(K_LD, 2'd3, 4'd2, 1'b1, 4'd3, 2'd0, 8, 6'd0);
    chk("R8 unrelated write keeps entry", 1'b1, 6'd15);
    modWr = 1'b1; modWrReg = 4'd2;
    issue(K_LD, 2'd3, 4'd2, 1'b1, 4'd3, 2'd0, 8, 6'd0);
    chk("R8 same-cycle base write misses", 1'b0, 6'd0);
    doFlush();
    modWr = 1'b1; modWrReg = 4'd2;
    st(2'd3, 4'd2, 0, 6'd16);
    ld(2'd3, 4'd2, 0);
    chk("R8 store in write cycle kept", 1'b1, 6'd16);

    // R9 stack tracking
    doFlush();
    issue(K_PUSH, 2'd3, 4'd0, 1'b0, 4'd0, 2'd0, 0, 6'd10);
    issue(K_PUSH, 2'd3, 4'd0, 1'b0, 4'd0, 2'd0, 0, 6'd11);
    issue(K_POP, 2'd3, 4'd0, 1'b0, 4'd0, 2'd0, 0, 6'd0);
    chk("R9 pop returns last push", 1'b1, 6'd11);
    issue(K_POP, 2'd3, 4'd0, 1'b0, 4'd0, 2'd0, 0, 6'd0);
    chk("R9 second pop", 1'b1, 6'd10);
    ld(2'd3, SP, -8);
    chk("R9 rebased below stack pointer", 1'b1, 6'd10);
    ld(2'd3, SP, -16);
    chk("R9 rebased twice", 1'b1, 6'd11);
    doFlush();
    st(2'd3, SP, 112, 6'd30);
    issue(K_PUSH, 2'd3, 4'd0, 1'b0, 4'd0, 2'd0, 0, 6'd31);
    ld(2'd3, SP, 120);
    chk("R9 push shifts store", 1'b1, 6'd30);
    issue(K_PUSH, 2'd3, 4'd0, 1'b0, 4'd0, 2'd0, 0, 6'd32);
    ld(2'd3, SP, 120);
    chk("R9 shifted out of range dropped", 1'b0, 6'd0);
    ld(2'd3, SP, 8);
    chk("R9 earlier push rebased", 1'b1, 6'd31);
    doFlush();
    st(2'd2, SP, 0, 6'd33);
    issue(K_PUSH, 2'd2, 4'd0, 1'b0, 4'd0, 2'd0, 0, 6'd34);
    ld(2'd2, SP, 4);
    chk("R9 32-bit push shifts by 4", 1'b1, 6'd33);
    doFlush();
    st(2'd3, SP, 0, 6'd35);
    issue(K_PUSH, 2'd1, 4'd0, 1'b0, 4'd0, 2'd0, 0, 6'd0);
    ld(2'd3, SP, 0);
    chk("R9 ineligible push drops stack entries", 1'b0, 6'd0);
    ld(2'd3, SP, 2);
    chk("R9 ineligible push no rebase", 1'b0, 6'd0);

    // R10 capacity and replacement
    doFlush();
    for (int i = 0; i < 9; i++) st(2'd3, 4'd5, i, 6'(i + 1));
    for (int j = 0; j < 9; j++) begin
      ld(2'd3, 4'd5, j);
      chk("R10 oldest replaced", j != 0, (j != 0) ? 6'(j + 1) : 6'd0);
    end
    st(2'd3, 4'd5, 3, 6'd20);
    st(2'd3, 4'd5, 9, 6'd21);
    ld(2'd3, 4'd5, 1);
    chk("R10 same key did not advance pointer", 1'b0, 6'd0);
    ld(2'd3, 4'd5, 3);
    chk("R10 same key overwritten", 1'b1, 6'd20);
    ld(2'd3, 4'd5, 9);
    chk("R10 new store placed", 1'b1, 6'd21);
    ld(2'd3, 4'd5, 2);
    chk("R10 other entry kept", 1'b1, 6'd3);

    // R11 flush
    doFlush();
    st(2'd3, 4'd1, 0, 6'd40);
    modFlush = 1'b1;
    ld(2'd3, 4'd1, 0);
    chk("R11 lookup in flush cycle misses", 1'b0, 6'd0);
    ld(2'd3, 4'd1, 0);
    chk("R11 table emptied", 1'b0, 6'd0);
    modFlush = 1'b1;
    st(2'd3, 4'd1, 0, 6'd41);
    ld(2'd3, 4'd1, 0);
    chk("R11 store in flush cycle dropped", 1'b0, 6'd0);

    finishRun();
  end

endmodule